// File: doc/BRIEF.md
# Host Bridge Address-Window Register File

This block holds the programming state of a host bridge's address windows: one configuration-space window, one message window, a parameterised number of outbound memory windows and one local register window. Each window has a 64-bit base and a mask whose bit 0 acts as the enable. Software reaches the registers through a simple 32-bit write/read port placed at a parameterised offset. The read path is combinational.

From the stored state the block derives three things. The first is the enable and byte size of the configuration window. The size is the two's complement of the mask with bit 0 cleared, and it is clamped to a parameterised maximum of 256 MiB by default. The second is a one-bit hit for every window, computed against a 64-bit probe address. The third is the special decode of the register window. The block moves no data and translates nothing. Other logic uses the hit vector and the configuration size to steer transactions.

Top module: `bridge_window_regs`

## Requirements
- R1: Registers sit at offsets 0..22 from `BASE_OFS` in this order: config base high/low (0,1), config mask (2), message base high/low (3,4), message mask (5), outbound window k (k=0..2) at 6+4k: base high, base low, mask high, mask low; register base high/low (18,19), register mask (20), a special word (21) and a control word (22). Writes to any other address change nothing, and reads of any other address return 0.
- R2: A write to a high or low half of a 64-bit base or mask replaces only that half.
- R3: Every register reads back the last value written to it, in all 32 bits.
- R4: `cfg_win_en` equals bit 0 of the config mask.
- R5: `cfg_win_size` equals 2^32 minus (config mask with bit 0 cleared), computed in 33 bits and clamped to 2^CFG_MAX_LOG2. A mask of 0xE0000001 therefore gives 0x10000000.
- R6: A register mask of exactly 0x00007001 selects a 4 KiB register window, which compares address bits 63..12. Any other register mask uses the normal compare rule of R7.
- R7: `win_hit` bit positions are: 0 config, 1 message, 2+k outbound window k, 2+OUT_WINS register. A window hits when its mask bit 0 is 1 and (address XOR base) AND (mask with bit 0 cleared) is zero. For the 32-bit masks, address bits 63..32 are always compared.
- R8: Reset, which is asynchronous and active low, clears every register. All windows are then disabled, and `cfg_win_size` reads 0x10000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| probe_addr | input | 64 | Address tested against all windows |
| cfg_win_en | output | 1 | Configuration window enable |
| cfg_win_size | output | 33 | Configuration window size in bytes |
| win_hit | output | OUT_WINS+3 | Per-window hit flags |

## Verification
A register write that re-programs a window can land in the same cycle in which the hit logic evaluates a probe address against that window. In that cycle the hit must still reflect the old state, and it must reflect the new state from the next cycle on. The bench holds the probe address steady on the message window and raises the mask's enable bit with a write. It samples `win_hit` once after driving the write and before the clock edge, where the bit must still be 0. It samples again after the edge, where the bit must be 1.

// File: rtl/bridge_window_regs.sv
module bridge_window_regs #(
  parameter int ADDR_W       = 10,
  parameter int BASE_OFS     = 'h40,
  parameter int OUT_WINS     = 3,
  parameter int CFG_MAX_LOG2 = 28
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [63:0]           probe_addr,
  output logic                  cfg_win_en,
  output logic [32:0]           cfg_win_size,
  output logic [OUT_WINS+2:0]   win_hit
);
  localparam int AW = ADDR_W + 1;
  localparam int OB0 = 6;
  localparam int RG0 = OB0 + 4 * OUT_WINS;
  localparam int NREGS = RG0 + 5;
  localparam logic [AW-1:0] O_CFG_BH = AW'(0);
  localparam logic [AW-1:0] O_CFG_BL = AW'(1);
  localparam logic [AW-1:0] O_CFG_M  = AW'(2);
  localparam logic [AW-1:0] O_MSG_BH = AW'(3);
  localparam logic [AW-1:0] O_MSG_BL = AW'(4);
  localparam logic [AW-1:0] O_MSG_M  = AW'(5);
  localparam logic [AW-1:0] O_REG_BH = AW'(RG0);
  localparam logic [AW-1:0] O_REG_BL = AW'(RG0 + 1);
  localparam logic [AW-1:0] O_REG_M  = AW'(RG0 + 2);
  localparam logic [AW-1:0] O_SPEC   = AW'(RG0 + 3);
  localparam logic [AW-1:0] O_CTRL   = AW'(RG0 + 4);
  localparam logic [32:0] CFG_MAX  = 33'(1) << CFG_MAX_LOG2;
  localparam logic [31:0] REG4K_CODE = 32'h0000_7001;

  logic [63:0] cfg_base, msg_base, reg_base;
  logic [31:0] cfg_mask, msg_mask, reg_mask, special_r, ctrl_r;
  logic [63:0] ob_base [OUT_WINS];
  logic [63:0] ob_mask [OUT_WINS];

  logic [AW-1:0] rel;
  logic          in_rng;
  assign rel    = {1'b0, reg_addr} - AW'(BASE_OFS);
  assign in_rng = !rel[AW-1] && (rel < AW'(NREGS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_base <= '0; msg_base <= '0; reg_base <= '0;
      cfg_mask <= '0; msg_mask <= '0; reg_mask <= '0;
      special_r <= '0; ctrl_r <= '0;
      for (int k = 0; k < OUT_WINS; k++) begin
        ob_base[k] <= '0;
        ob_mask[k] <= '0;
      end
    end else if (reg_we && in_rng) begin
      case (rel)
        O_CFG_BH: cfg_base[63:32] <= reg_wdata;
        O_CFG_BL: cfg_base[31:0]  <= reg_wdata;
        O_CFG_M:  cfg_mask        <= reg_wdata;
        O_MSG_BH: msg_base[63:32] <= reg_wdata;
        O_MSG_BL: msg_base[31:0]  <= reg_wdata;
        O_MSG_M:  msg_mask        <= reg_wdata;
        O_REG_BH: reg_base[63:32] <= reg_wdata;
        O_REG_BL: reg_base[31:0]  <= reg_wdata;
        O_REG_M:  reg_mask        <= reg_wdata;
        O_SPEC:   special_r       <= reg_wdata;
        O_CTRL:   ctrl_r          <= reg_wdata;
        default: ;
      endcase
      for (int k = 0; k < OUT_WINS; k++) begin
        if (rel == AW'(OB0 + 4 * k))     ob_base[k][63:32] <= reg_wdata;
        if (rel == AW'(OB0 + 4 * k + 1)) ob_base[k][31:0]  <= reg_wdata;
        if (rel == AW'(OB0 + 4 * k + 2)) ob_mask[k][63:32] <= reg_wdata;
        if (rel == AW'(OB0 + 4 * k + 3)) ob_mask[k][31:0]  <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_rng) begin
      case (rel)
        O_CFG_BH: reg_rdata = cfg_base[63:32];
        O_CFG_BL: reg_rdata = cfg_base[31:0];
        O_CFG_M:  reg_rdata = cfg_mask;
        O_MSG_BH: reg_rdata = msg_base[63:32];
        O_MSG_BL: reg_rdata = msg_base[31:0];
        O_MSG_M:  reg_rdata = msg_mask;
        O_REG_BH: reg_rdata = reg_base[63:32];
        O_REG_BL: reg_rdata = reg_base[31:0];
        O_REG_M:  reg_rdata = reg_mask;
        O_SPEC:   reg_rdata = special_r;
        O_CTRL:   reg_rdata = ctrl_r;
        default: ;
      endcase
      for (int k = 0; k < OUT_WINS; k++) begin
        if (rel == AW'(OB0 + 4 * k))     reg_rdata = ob_base[k][63:32];
        if (rel == AW'(OB0 + 4 * k + 1)) reg_rdata = ob_base[k][31:0];
        if (rel == AW'(OB0 + 4 * k + 2)) reg_rdata = ob_mask[k][63:32];
        if (rel == AW'(OB0 + 4 * k + 3)) reg_rdata = ob_mask[k][31:0];
      end
    end
  end

  logic [32:0] cfg_raw;
  logic [63:0] cfg_cmp, msg_cmp, reg_cmp;
  assign cfg_raw      = 33'h1_0000_0000 - {1'b0, cfg_mask[31:1], 1'b0};
  assign cfg_win_en   = cfg_mask[0];
  assign cfg_win_size = (cfg_raw > CFG_MAX) ? CFG_MAX : cfg_raw;

  assign cfg_cmp = {32'hFFFF_FFFF, cfg_mask[31:1], 1'b0};
  assign msg_cmp = {32'hFFFF_FFFF, msg_mask[31:1], 1'b0};
  assign reg_cmp = (reg_mask == REG4K_CODE) ? 64'hFFFF_FFFF_FFFF_F000
                                            : {32'hFFFF_FFFF, reg_mask[31:1], 1'b0};

  assign win_hit[0] = cfg_mask[0] && (((probe_addr ^ cfg_base) & cfg_cmp) == '0);
  assign win_hit[1] = msg_mask[0] && (((probe_addr ^ msg_base) & msg_cmp) == '0);
  assign win_hit[OUT_WINS+2] = reg_mask[0] && (((probe_addr ^ reg_base) & reg_cmp) == '0);

  for (genvar k = 0; k < OUT_WINS; k++) begin : g_ob
    assign win_hit[2+k] = ob_mask[k][0] &&
        (((probe_addr ^ ob_base[k]) & {ob_mask[k][63:1], 1'b0}) == '0);
  end

  a_r1_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && !in_rng |=> $stable({cfg_base, cfg_mask, reg_mask, special_r, ctrl_r}));
  a_r2_low_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && in_rng && rel == O_CFG_BL |=> $stable(cfg_base[63:32]));
  a_r3_readback: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && in_rng && rel == O_SPEC |=> special_r == $past(reg_wdata));
  a_r5_size_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_win_size <= CFG_MAX && cfg_win_size != '0);
  a_r7_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit[OUT_WINS+2] |-> reg_mask[0]);
  a_r8_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (cfg_mask == '0 && special_r == '0 && win_hit == '0));
endmodule

// File: tb/bridge_window_regs_test.sv
module bridge_window_regs_test;
  localparam int ADDR_W = 10;
  localparam int BASE   = 'h40;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] probe_addr = '0;
  logic        cfg_win_en;
  logic [32:0] cfg_win_size;
  logic [5:0]  win_hit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bridge_window_regs #(.ADDR_W(ADDR_W), .BASE_OFS(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .probe_addr(probe_addr),
    .cfg_win_en(cfg_win_en), .cfg_win_size(cfg_win_size), .win_hit(win_hit));

  localparam logic [36:0] VEC [23] = '{
    {5'd0,  32'h1111_0000}, {5'd1,  32'h2222_0001}, {5'd2,  32'h3333_0002},
    {5'd3,  32'h4444_0003}, {5'd4,  32'h5555_0004}, {5'd5,  32'h6666_0005},
    {5'd6,  32'h7777_0006}, {5'd7,  32'h8888_0007}, {5'd8,  32'h9999_0008},
    {5'd9,  32'hAAAA_0009}, {5'd10, 32'hBBBB_000A}, {5'd11, 32'hCCCC_000B},
    {5'd12, 32'hDDDD_000C}, {5'd13, 32'hEEEE_000D}, {5'd14, 32'hFFFF_000E},
    {5'd15, 32'h0F0F_000F}, {5'd16, 32'hF0F0_0010}, {5'd17, 32'h1234_0011},
    {5'd18, 32'h5678_0012}, {5'd19, 32'h9ABC_0013}, {5'd20, 32'hDEF0_0014},
    {5'd21, 32'hCAFE_0015}, {5'd22, 32'hBEEF_0016}};

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int off, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = ADDR_W'(BASE + off); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(int off, output logic [31:0] d);
    reg_addr = ADDR_W'(BASE + off);
    #1 d = reg_rdata;
  endtask

  task automatic probe(logic [63:0] a);
    probe_addr = a;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    logic [31:0] d;
    do_reset();
    // R8: reset state
    for (int i = 0; i < 23; i++) begin
      rd(i, d);
      chk($sformatf("R8 reset reg %0d", i), d, 0);
    end
    probe(64'h0);
    chk("R8 reset hits", win_hit, 0);
    chk("R8 reset cfg_win_en", cfg_win_en, 0);
    chk("R8 reset cfg_win_size", cfg_win_size, 33'h1000_0000);

    // R3: table of writes then immediate readback
    for (int i = 0; i < 23; i++) begin
      wr(int'(VEC[i][36:32]), VEC[i][31:0]);
      rd(int'(VEC[i][36:32]), d);
      chk($sformatf("R3 readback reg %0d", i), d, VEC[i][31:0]);
    end
    // R2/R1: no cross-talk between halves or neighbours
    for (int i = 0; i < 23; i++) begin
      rd(int'(VEC[i][36:32]), d);
      chk($sformatf("R2 recheck reg %0d", i), d, VEC[i][31:0]);
    end

    do_reset();
    // R4 / R5: config window size and clamp
    wr(0, 32'h0000_0001); wr(1, 32'hC000_0000); wr(2, 32'hF000_0001);
    chk("R4 cfg enable", cfg_win_en, 1);
    chk("R5 size exact limit", cfg_win_size, 33'h1000_0000);
    probe(64'h1_C123_4567);
    chk("R7 cfg hit", win_hit, 6'b000001);
    probe(64'h2_C123_4567);
    chk("R7 cfg upper bits compared", win_hit, 0);
    wr(2, 32'hFFF0_0001);
    chk("R5 size 1MiB", cfg_win_size, 33'h0010_0000);
    probe(64'h1_C00F_FFFF);
    chk("R7 cfg hit small", win_hit, 6'b000001);
    probe(64'h1_C010_0000);
    chk("R7 cfg miss small", win_hit, 0);
    wr(2, 32'hE000_0001);
    chk("R5 clamp E0000001", cfg_win_size, 33'h1000_0000);
    wr(2, 32'hF000_0000);
    chk("R4 cfg disabled", cfg_win_en, 0);

    // R6: register window special code
    wr(18, 32'h0); wr(19, 32'h1234_5000); wr(20, 32'h0000_7001);
    probe(64'h1234_5FFF);
    chk("R6 4KiB hit", win_hit, 6'b100000);
    probe(64'h1234_D000);
    chk("R6 4KiB miss", win_hit, 0);
    wr(20, 32'h0000_7000);
    probe(64'h1234_5FFF);
    chk("R7 reg disabled", win_hit, 0);
    wr(20, 32'hFFFF_0001);
    probe(64'h1234_D000);
    chk("R6 normal rule hit", win_hit, 6'b100000);
    wr(20, 32'h0);

    // R7 / R2: outbound window 1 (hit bit 3)
    wr(10, 32'h0000_0008); wr(11, 32'h00A1_0000);
    wr(12, 32'hFFFF_FFFF); wr(13, 32'hFFFF_0001);
    probe(64'h8_00A1_1234);
    chk("R7 outbound hit", win_hit, 6'b001000);
    probe(64'h9_00A1_1234);
    chk("R7 outbound high mask miss", win_hit, 0);
    wr(11, 32'h00B2_0000);
    rd(10, d);
    chk("R2 base high kept", d, 32'h8);
    probe(64'h8_00B2_0000);
    chk("R2 outbound new low", win_hit, 6'b001000);

    // R7: same-cycle write and hit on the message window
    wr(3, 32'h0); wr(4, 32'h4000_0000); wr(5, 32'hFFFF_0000);
    probe(64'h4000_1234);
    chk("R7 msg disabled", win_hit[1], 0);
    @(negedge clk);
    reg_we = 1; reg_addr = ADDR_W'(BASE + 5); reg_wdata = 32'hFFFF_0001;
    #1 chk("R7 msg hit old state in write cycle", win_hit[1], 0);
    @(posedge clk); #1;
    chk("R7 msg hit after write", win_hit[1], 1);
    @(negedge clk); reg_we = 0;

    // R1: out-of-range accesses
    wr(21, 32'h5555_AAAA);
    wr(23, 32'hDEAD_BEEF);
    wr(-1, 32'hDEAD_BEEF);
    rd(21, d);
    chk("R1 special untouched", d, 32'h5555_AAAA);
    rd(22, d);
    chk("R1 ctrl untouched", d, 0);
    rd(23, d);
    chk("R1 read above range", d, 0);
    rd(-1, d);
    chk("R1 read below range", d, 0);

    // R8: reset mid-run
    do_reset();
    rd(21, d);
    chk("R8 special cleared", d, 0);
    probe(64'h4000_1234);
    chk("R8 hits cleared", win_hit, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule